// File: doc/BRIEF.md
# SPI DMA Byte Pacing Controller

This block paces a DMA-fed SPI transmit path. A shift engine reports each byte it finishes. The block then decides when the next byte may be written into the transmit buffer, and when the processor should be interrupted. It does neither the shifting nor the memory traffic. It only watches the completion strobe and the remaining-byte count from the DMA engine, and it produces a load permit and one interrupt line. One clock cycle of the block equals one instruction cycle.

In master mode, every completed byte opens a gap before the next load. The gap is a fixed base that depends on the SPI clock divider, plus an extra amount. When the delay-interrupt enable is clear, the extra amount comes from a 4-bit delay code whose scale is logarithmic first and then linear. When the enable is set, the extra amount shrinks to one cycle, and the delay code instead times an interrupt measured from the last completed byte. In slave mode the gap is a single cycle, and the delay code can only produce that timeout interrupt. A separate 4-bit watermark code chooses a remaining-byte level, and the block interrupts once when the DMA count reaches it.

Top module: `spi_dma_pacer`

## Requirements
- R1: While reset is asserted and after it is released, with no byte completed, `load_ok_o` is 1 and `irq_o` is 0.
- R2: A completion sampled at clock edge E0 drops `load_ok_o` after E0, and it stays 0 until it rises after edge E0+N. In master mode N = base + extra. The base is 8, 9 or 15 for `div_sel_i` = 0 (divide by 4), 1 (divide by 16) and 2 (divide by 64). Value 3 also means divide by 64.
- R3: Delay code c decodes to D cycles as follows. For c in 0..7, D = 2^c. For c in 8..14, D = 128*(c-6). For c = 15, D = 2048.
- R4: In master mode with `dly_irq_en_i` = 0, extra = D, and no timeout interrupt is raised.
- R5: In master mode with `dly_irq_en_i` = 1, extra = 1, and `irq_o` is high for exactly the one cycle after edge E0+D.
- R6: In slave mode (`master_i` = 0), N = 1. A timeout interrupt follows R5's timing only when `dly_irq_en_i` = 1.
- R7: A completion always restarts the timeout count. A pending timeout interrupt is dropped when a new byte completes before it expires, and the interrupt is re-armed only if the enable is 1 at that new completion.
- R8: The mode, divider, delay code, enable and watermark code are used only at a completion. Changing them during a gap leaves that gap and any pending interrupt unchanged.
- R9: Watermark code w selects level L as follows. For w = 0, L = 0. For w in 1..7, L = 2^(w-1). For w in 8..15, L = 64*(w-6). `irq_o` pulses in the cycle after the first cycle in which `bytes_left_i` equals L.
- R10: The watermark does not fire again while the count stays at L. A watermark code change without a completion has no effect.
- R11: `irq_o` is a one-cycle pulse. Both interrupt sources drive the same line, and no interrupt occurs without a cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Instruction-cycle clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| byte_done_i | input | 1 | One-cycle strobe from the shifter when a byte finishes |
| bytes_left_i | input | CNT_W | Remaining-byte count from the DMA engine |
| master_i | input | 1 | 1 = master mode, 0 = slave mode |
| div_sel_i | input | 2 | SPI clock divider: 0 = /4, 1 = /16, 2 or 3 = /64 |
| delay_code_i | input | 4 | Delay code (R3) |
| wmark_code_i | input | 4 | Watermark code (R9) |
| dly_irq_en_i | input | 1 | 1 = delay times an interrupt, 0 = delay spaces bytes |
| load_ok_o | output | 1 | High when the next byte may be loaded |
| irq_o | output | 1 | One-cycle interrupt pulse |

## Verification
A gap counter loaded with a wrong length shows up at `load_ok_o` as a rising edge in the wrong cycle. This appears at the latest 2063 cycles after the completion that loaded it. A stale or wrongly armed timeout shows up as an interrupt that is early, late, missing or unrequested, measured from the last completion. A wrong watermark latch or previous-match flag shows up as a missing or repeated pulse when the count reaches the level. A scoreboard of expected edges, each with its cycle number, makes the checks exact to the cycle. Idle stretches are watched so that unrequested pulses are caught.

// File: rtl/spi_pace_pkg.sv
package spi_pace_pkg;

  localparam int CODE_W = 4;   // width of delay and watermark codes
  localparam int DLY_W  = 12;  // holds the largest decoded delay (2048)
  localparam int WM_W   = 10;  // holds the largest watermark level (576)
  localparam int BASE_W = 4;   // holds the largest base gap (15)

  typedef enum logic [1:0] {
    SCK_DIV4   = 2'd0,
    SCK_DIV16  = 2'd1,
    SCK_DIV64  = 2'd2,
    SCK_DIV64B = 2'd3
  } sck_div_e;

  // log-then-linear delay scale
  function automatic logic [DLY_W-1:0] delay_cycles(input logic [CODE_W-1:0] code);
    logic [DLY_W-1:0] val;
    if (code == 4'hF)
      val = DLY_W'(2048);
    else if (code[3])
      val = DLY_W'(code - 4'd6) << 7;
    else
      val = DLY_W'(1) << code[2:0];
    return val;
  endfunction

  // remaining-byte level picked by a watermark code
  function automatic logic [WM_W-1:0] wmark_level(input logic [CODE_W-1:0] code);
    logic [WM_W-1:0] val;
    if (code == 4'h0)
      val = '0;
    else if (!code[3])
      val = WM_W'(1) << (code[2:0] - 3'd1);
    else
      val = WM_W'(code - 4'd6) << 6;
    return val;
  endfunction

  // fixed master gap per SPI clock divider
  function automatic logic [BASE_W-1:0] base_gap(input sck_div_e div);
    logic [BASE_W-1:0] val;
    case (div)
      SCK_DIV4:  val = BASE_W'(8);
      SCK_DIV16: val = BASE_W'(9);
      default:   val = BASE_W'(15);
    endcase
    return val;
  endfunction

endpackage

// File: rtl/spi_pace_gap.sv
module spi_pace_gap #(
  parameter int GAP_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [GAP_W-1:0] len_i,
  output logic             load_ok_o
);

  logic [GAP_W-1:0] gap_q, gap_d;
  logic             gap_en;

  always_comb begin
    gap_en = start_i || (gap_q != '0);
    gap_d  = start_i ? len_i : (gap_q - GAP_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      gap_q <= '0;
    else if (gap_en) gap_q <= gap_d;
  end

  assign load_ok_o = (gap_q == '0);

  // R2
  gap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> !load_ok_o);

  // R2
  gap_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && gap_q != '0) |=> (gap_q == $past(gap_q) - GAP_W'(1)));

endmodule

// File: rtl/spi_pace_tmo.sv
module spi_pace_tmo #(
  parameter int TMO_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             arm_i,
  input  logic [TMO_W-1:0] len_i,
  output logic             fire_o
);

  logic [TMO_W-1:0] cnt_q, cnt_d;
  logic             armed_q, armed_d;
  logic             fire_q, fire_d;
  logic             cnt_en, expire;

  always_comb begin
    expire  = armed_q && (cnt_q == TMO_W'(1));
    cnt_en  = start_i || (cnt_q != '0);
    cnt_d   = start_i ? len_i : (cnt_q - TMO_W'(1));
    armed_d = armed_q;
    fire_d  = 1'b0;
    if (start_i) begin
      armed_d = arm_i;
    end else if (expire) begin
      armed_d = 1'b0;
      fire_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      fire_q  <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      armed_q <= armed_d;
      fire_q  <= fire_d;
    end
  end

  assign fire_o = fire_q;

  // R7
  tmo_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> !fire_o);

  // R4
  tmo_unarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !arm_i) |=> !armed_q);

endmodule

// File: rtl/spi_pace_wmark.sv
module spi_pace_wmark
  import spi_pace_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic              fire_o
);

  logic [CODE_W-1:0] code_q;
  logic              hit, hit_q, fire_q;

  always_comb begin
    hit = (count_i == CNT_W'(wmark_level(code_q)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      hit_q  <= 1'b1;
      fire_q <= 1'b0;
    end else begin
      if (sample_i) code_q <= code_i;
      hit_q  <= hit;
      fire_q <= hit && !hit_q;
    end
  end

  assign fire_o = fire_q;

  // R10
  wm_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |=> !fire_o);

  // R10
  wm_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_i |=> $stable(code_q));

endmodule

// File: rtl/spi_dma_pacer.sv
module spi_dma_pacer
  import spi_pace_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_done_i,
  input  logic [CNT_W-1:0] bytes_left_i,
  input  logic             master_i,
  input  logic [1:0]       div_sel_i,
  input  logic [3:0]       delay_code_i,
  input  logic [3:0]       wmark_code_i,
  input  logic             dly_irq_en_i,
  output logic             load_ok_o,
  output logic             irq_o
);

  localparam int GAP_W = DLY_W + 1;

  logic [GAP_W-1:0] gap_len;
  logic [DLY_W-1:0] dly_val;
  logic [GAP_W-1:0] base_ext;
  logic             tmo_fire, wm_fire;

  always_comb begin
    dly_val  = delay_cycles(delay_code_i);
    base_ext = GAP_W'(base_gap(sck_div_e'(div_sel_i)));
    if (!master_i)
      gap_len = GAP_W'(1);
    else if (dly_irq_en_i)
      gap_len = base_ext + GAP_W'(1);
    else
      gap_len = base_ext + GAP_W'(dly_val);
  end

  spi_pace_gap #(.GAP_W(GAP_W)) gap_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (byte_done_i),
    .len_i     (gap_len),
    .load_ok_o (load_ok_o)
  );

  spi_pace_tmo #(.TMO_W(DLY_W)) tmo_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (byte_done_i),
    .arm_i   (dly_irq_en_i),
    .len_i   (dly_val),
    .fire_o  (tmo_fire)
  );

  spi_pace_wmark #(.CNT_W(CNT_W)) wm_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .sample_i (byte_done_i),
    .code_i   (wmark_code_i),
    .count_i  (bytes_left_i),
    .fire_o   (wm_fire)
  );

  assign irq_o = tmo_fire | wm_fire;

  // R6
  slave_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done_i && !master_i) ##1 !byte_done_i |=> load_ok_o);

  // R2
  master_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done_i && master_i) ##1 !byte_done_i |=> !load_ok_o);

endmodule

// File: tb/spi_dma_pacer_tb_top.sv
module spi_dma_pacer_tb_top;

  localparam int EV_LOAD = 0;
  localparam int EV_IRQ  = 1;

  typedef struct {
    int    kind;
    int    cyc;
    string req;
  } ev_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       byte_done = 1'b0;
  logic [9:0] bytes_left = 10'd700;
  logic       master = 1'b1;
  logic [1:0] div_sel = 2'd0;
  logic [3:0] delay_code = 4'd0;
  logic [3:0] wmark_code = 4'd0;
  logic       dly_irq_en = 1'b0;
  logic       load_ok, irq;

  int   cyc = 0;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   mon_en = 1'b0;
  logic load_prev = 1'b1;
  ev_t  exp_q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  spi_dma_pacer #(.CNT_W(10)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .byte_done_i  (byte_done),
    .bytes_left_i (bytes_left),
    .master_i     (master),
    .div_sel_i    (div_sel),
    .delay_code_i (delay_code),
    .wmark_code_i (wmark_code),
    .dly_irq_en_i (dly_irq_en),
    .load_ok_o    (load_ok),
    .irq_o        (irq)
  );

  // expected values from the requirement text
  function automatic int exp_delay(input int c);
    case (c)
      0: return 1;    1: return 2;    2: return 4;    3: return 8;
      4: return 16;   5: return 32;   6: return 64;   7: return 128;
      8: return 256;  9: return 384;  10: return 512; 11: return 640;
      12: return 768; 13: return 896; 14: return 1024; default: return 2048;
    endcase
  endfunction

  function automatic int exp_base(input int d);
    case (d)
      0: return 8;
      1: return 9;
      default: return 15;
    endcase
  endfunction

  function automatic int exp_wm(input int w);
    case (w)
      0: return 0;    1: return 1;    2: return 2;    3: return 4;
      4: return 8;    5: return 16;   6: return 32;   7: return 64;
      8: return 128;  9: return 192;  10: return 256; 11: return 320;
      12: return 384; 13: return 448; 14: return 512; default: return 576;
    endcase
  endfunction

  function automatic string kname(input int k);
    return (k == EV_LOAD) ? "load-permit rise" : "irq pulse";
  endfunction

  task automatic push(input int k, input int c, input string r);
    ev_t e;
    e.kind = k;
    e.cyc  = c;
    e.req  = r;
    exp_q.push_back(e);
  endtask

  task automatic chk(input bit ok, input string r, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s actual %0d expected %0d (cycle %0d)", r, what, act, exp, cyc);
    end
  endtask

  task automatic observe(input int k);
    n_chk++;
    if (exp_q.size() > 0 && exp_q[0].kind == k && exp_q[0].cyc == cyc) begin
      void'(exp_q.pop_front());
    end else begin
      n_fail++;
      if (exp_q.size() > 0)
        $display("FAIL %s: actual %s at cycle %0d, expected %s at cycle %0d",
                 exp_q[0].req, kname(k), cyc, kname(exp_q[0].kind), exp_q[0].cyc);
      else
        $display("FAIL R11: actual %s at cycle %0d, expected no event", kname(k), cyc);
    end
  endtask

  // monitor: compares observed edges with the scoreboard
  always @(negedge clk) begin
    if (mon_en) begin
      while (exp_q.size() > 0 && exp_q[0].cyc < cyc) begin
        n_chk++;
        n_fail++;
        $display("FAIL %s: actual no %s by cycle %0d, expected at cycle %0d",
                 exp_q[0].req, kname(exp_q[0].kind), cyc, exp_q[0].cyc);
        void'(exp_q.pop_front());
      end
      if (load_ok && !load_prev) observe(EV_LOAD);
      if (irq) observe(EV_IRQ);
    end
    load_prev = load_ok;
  end

  task automatic send_byte(input logic m, input logic [1:0] dv, input logic [3:0] dc,
                           input logic [3:0] wc, input logic en, output int e0);
    @(negedge clk);
    master     = m;
    div_sel    = dv;
    delay_code = dc;
    wmark_code = wc;
    dly_irq_en = en;
    byte_done  = 1'b1;
    e0 = cyc + 1;
    @(negedge clk);
    byte_done = 1'b0;
  endtask

  task automatic set_cnt(input int v);
    @(negedge clk);
    bytes_left = 10'(v);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual run still busy at cycle %0d, expected done", cyc);
    finish_run();
  end

  initial begin
    int e0, e1, lvl;
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    chk(load_ok == 1'b1, "R1", "load_ok in reset", int'(load_ok), 1);
    chk(irq == 1'b0, "R1", "irq in reset", int'(irq), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(load_ok == 1'b1, "R1", "load_ok after reset", int'(load_ok), 1);
    chk(irq == 1'b0, "R1", "irq after reset", int'(irq), 0);
    mon_en = 1'b1;

    // R2: divide by 4, code 0, spacing mode
    send_byte(1'b1, 2'd0, 4'd0, 4'd0, 1'b0, e0);
    chk(load_ok == 1'b0, "R2", "load_ok right after completion", int'(load_ok), 0);
    push(EV_LOAD, e0 + 9, "R2");
    drain();

    // R3 / R4: every delay code, divider cycling
    for (int c = 0; c < 16; c++) begin
      send_byte(1'b1, 2'(c % 4), 4'(c), 4'd0, 1'b0, e0);
      push(EV_LOAD, e0 + exp_base(c % 4) + exp_delay(c), "R3");
      drain();
    end

    // R5: interrupt mode in master, D=16 at divide by 16
    send_byte(1'b1, 2'd1, 4'd4, 4'd0, 1'b1, e0);
    push(EV_LOAD, e0 + 10, "R5");
    push(EV_IRQ, e0 + 16, "R5");
    drain();
    // R5: D=1, the interrupt comes before the permit
    send_byte(1'b1, 2'd0, 4'd0, 4'd0, 1'b1, e0);
    push(EV_IRQ, e0 + 1, "R5");
    push(EV_LOAD, e0 + 9, "R5");
    drain();

    // R6: slave without interrupt, long idle watch
    send_byte(1'b0, 2'd2, 4'd5, 4'd0, 1'b0, e0);
    push(EV_LOAD, e0 + 1, "R6");
    drain();
    repeat (60) @(negedge clk);
    // R6: slave with timeout interrupt
    send_byte(1'b0, 2'd0, 4'd2, 4'd0, 1'b1, e0);
    push(EV_LOAD, e0 + 1, "R6");
    push(EV_IRQ, e0 + 4, "R6");
    drain();

    // R7: restart by a new byte
    send_byte(1'b0, 2'd0, 4'd5, 4'd0, 1'b1, e0);
    push(EV_LOAD, e0 + 1, "R7");
    repeat (9) @(negedge clk);
    send_byte(1'b0, 2'd0, 4'd5, 4'd0, 1'b1, e1);
    push(EV_LOAD, e1 + 1, "R7");
    push(EV_IRQ, e1 + 32, "R7");
    drain();
    // R7: cancel by a byte with the enable clear
    send_byte(1'b0, 2'd0, 4'd4, 4'd0, 1'b1, e0);
    push(EV_LOAD, e0 + 1, "R7");
    repeat (4) @(negedge clk);
    send_byte(1'b0, 2'd0, 4'd4, 4'd0, 1'b0, e1);
    push(EV_LOAD, e1 + 1, "R7");
    drain();
    repeat (40) @(negedge clk);

    // R8: control changes in mid-gap
    send_byte(1'b1, 2'd0, 4'd6, 4'd0, 1'b0, e0);
    push(EV_LOAD, e0 + 72, "R8");
    repeat (10) @(negedge clk);
    delay_code = 4'd15;
    div_sel    = 2'd2;
    dly_irq_en = 1'b1;
    master     = 1'b0;
    repeat (10) @(negedge clk);
    chk(load_ok == 1'b0, "R8", "load_ok mid-gap after control change", int'(load_ok), 0);
    drain();

    // R9 / R10 / R11: every watermark code
    for (int w = 0; w < 16; w++) begin
      lvl = exp_wm(w);
      set_cnt(lvl + 3);
      send_byte(1'b0, 2'd0, 4'd0, 4'(w), 1'b0, e0);
      push(EV_LOAD, e0 + 1, "R9");
      set_cnt(lvl + 2);
      set_cnt(lvl + 1);
      set_cnt(lvl);
      push(EV_IRQ, cyc + 1, "R9");
      @(negedge clk);
      @(negedge clk);
      chk(irq == 1'b0, "R11", "irq one cycle after watermark pulse", int'(irq), 0);
      repeat (4) @(negedge clk);
      if (lvl > 0) set_cnt(lvl - 1);
      drain();
    end

    // R10: code change without a completion is ignored (latched level 576)
    set_cnt(70);
    @(negedge clk);
    wmark_code = 4'd7;
    set_cnt(64);
    repeat (10) @(negedge clk);
    chk(irq == 1'b0, "R10", "irq with unsampled watermark code", int'(irq), 0);
    set_cnt(576);
    push(EV_IRQ, cyc + 1, "R10");
    drain();
    repeat (10) @(negedge clk);

    chk(exp_q.size() == 0, "R11", "events left in scoreboard", exp_q.size(), 0);
    finish_run();
  end

endmodule